// File: doc/BRIEF.md
# Page-Tag Gathering Packet Transmitter

This block sends one packet at a time onto a single outbound virtual channel. A host describes the packet as a list of page tags. Each tag gives the base address of one page in a word-wide buffer memory and the number of 32-bit words on that page. A flag in the tag marks the last page of the packet. The pages may sit anywhere in memory, and the block concatenates them in tag order.

Before it touches memory for a new packet, the block requests the outbound channel and waits for a grant. It then reads the payload words through a synchronous read port and folds each word into a running CRC. After the final payload word it sends a transmit timestamp word and then the CRC word. Every word leaves through a byte-wide valid/ready link interface. Once the link has accepted the last CRC byte, the channel request drops.

Top module: `page_tag_tx`

## Requirements
- R1: A tag is taken when `tag_valid` and `tag_ready` are both high at a clock edge. Up to `FIFO_DEPTH` tags are held, and `tag_ready` is low while that many are held. After reset `tag_ready` is 1 and `chan_req`, `mem_rd_en` and `link_valid` are 0.
- R2: `chan_req` rises when a tag is waiting and no packet is in progress. No memory read is issued and no link byte is offered until `chan_grant` has been sampled high while `chan_req` is high.
- R3: For each tag the block reads `tag_count` words (1 or more) from addresses `tag_addr`, `tag_addr+1`, and so on. Tags are taken in arrival order, and their pages form the payload back to back.
- R4: Memory reads have a latency of one cycle: data for a read issued at one edge is taken from `mem_rd_data` at the next edge. Reads are never issued on two consecutive cycles.
- R5: Each word goes out as four bytes, most significant byte first. A byte is transferred at an edge where `link_valid` and `link_ready` are both high. While `link_ready` is low, `link_valid` and `link_byte` hold.
- R6: The packet on the link is the payload words, then one timestamp word, then one CRC word, and nothing else.
- R7: The timestamp counter is 0 at reset and increases by 1 every clock. The word sent is the counter value at the edge where the read of the packet's last payload word is issued.
- R8: The CRC is the non-reflected, MSB-first polynomial 0x04C11DB7 over the payload words, each word taken from bit 31 down to bit 0. It starts at 0xFFFFFFFF for every packet and is sent without final inversion.
- R9: `chan_req` stays high until the last CRC byte is accepted. It falls within two cycles after that, and no byte is offered while it is low.
- R10: The tag with `tag_last` = 1 closes the packet. Tags without it continue the same packet, and the block waits for the host when it has no further tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tag_valid | input | 1 | Host offers a page tag |
| tag_ready | output | 1 | Tag queue has room |
| tag_addr | input | ADDR_W | Page base word address |
| tag_count | input | CNT_W | Words on the page (at least 1) |
| tag_last | input | 1 | Page is the last of its packet |
| chan_req | output | 1 | Outbound channel reservation request |
| chan_grant | input | 1 | Reservation granted |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| link_valid | output | 1 | Byte offered to the link |
| link_ready | input | 1 | Link accepts the byte |
| link_byte | output | 8 | Byte to the link |

## Verification
The bench goes after a packet that is a single one-word page. If the timestamp were taken at the wrong fetch, or the trailer were misplaced, that packet would show it at once. It holds off the grant while the tag queue fills, so a design that fetched early or overfilled its queue would be caught. Slow host tag delivery between pages checks that the block waits rather than closing the packet early. Back-to-back packets under random link stalls catch a CRC that is not reseeded, bytes that are reordered or repeated under backpressure, and a reservation released before the last byte leaves.

// File: rtl/ptx_pkg.sv
// Shared definitions for the page-tag transmitter: control states and
// the word-wide CRC step. Assumes 32-bit payload words.
package ptx_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GRANT, ST_READ, ST_DATA, ST_WAIT, ST_STAMP, ST_CRC, ST_FIN
    } ptx_state_e;

    // Folds one 32-bit word into the CRC, bit 31 first, no reflection.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [31:0] word);
        logic [31:0] c;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            if (c[31] ^ word[i]) c = {c[30:0], 1'b0} ^ CRC_POLY;
            else                 c = {c[30:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/ptx_tag_fifo.sv
// Small synchronous FIFO that queues page tags from the host.
// Assumes DEPTH is a power of two, at least 2. Read data is the head entry.
module ptx_tag_fifo #(
    parameter int W     = 15,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] store [DEPTH];
    logic [PW:0]  wr_ptr, rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
    assign dout  = store[rd_ptr[PW-1:0]];

    // Pointer update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full)  wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Entry write.
    always_ff @(posedge clk) begin
        if (push && !full) store[wr_ptr[PW-1:0]] <= din;
    end

endmodule

// File: rtl/ptx_crc_acc.sv
// Running CRC register over payload words. Reseeded by clear, which
// takes precedence over a word update in the same cycle.
module ptx_crc_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [31:0] word,
    output logic [31:0] crc
);
    import ptx_pkg::*;

    // Seed or fold in one word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= CRC_SEED;
        else if (en)         crc <= crc_step(crc, word);
    end

endmodule

// File: rtl/ptx_byte_ser.sv
// Splits a loaded word into bytes, most significant first, each moved
// by a valid/ready handshake. Load is only legal while busy is low.
module ptx_byte_ser #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              ready,
    output logic              busy,
    output logic [7:0]        byte_o
);
    localparam int NB   = WORD_W / 8;
    localparam int CNTW = $clog2(NB);

    logic [WORD_W-1:0] shreg;
    logic [CNTW-1:0]   idx;

    assign byte_o = shreg[WORD_W-1 -: 8];

    // Load a word, then shift one byte out per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            shreg <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            idx   <= '0;
            shreg <= word;
        end else if (busy && ready) begin
            shreg <= shreg << 8;
            idx   <= idx + 1'b1;
            if (idx == CNTW'(NB - 1)) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/page_tag_tx.sv
// Gathers one packet from tagged memory pages, appends a timestamp and
// CRC trailer, and sends it bytewise after reserving the outbound channel.
// Assumes every tag count is at least 1 and memory read latency is one cycle.
module page_tag_tx #(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 6,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_valid,
    output logic              tag_ready,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [CNT_W-1:0]  tag_count,
    input  logic              tag_last,
    output logic              chan_req,
    input  logic              chan_grant,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              link_valid,
    input  logic              link_ready,
    output logic [7:0]        link_byte
);
    import ptx_pkg::*;

    localparam int TAG_W = ADDR_W + CNT_W + 1;

    ptx_state_e        state, nxt;
    logic [TAG_W-1:0]  head;
    logic              q_empty, q_full, q_pop;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  rem;
    logic              cur_last;
    logic [31:0]       ts_cnt, ts_q, crc;
    logic              ser_load, ser_busy, crc_clr, crc_en;
    logic [31:0]       ser_word;

    ptx_tag_fifo #(.W(TAG_W), .DEPTH(FIFO_DEPTH)) tagq_i (
        .clk(clk), .rst_n(rst_n),
        .push(tag_valid), .din({tag_last, tag_count, tag_addr}),
        .pop(q_pop), .dout(head), .empty(q_empty), .full(q_full)
    );

    ptx_crc_acc crc_i (
        .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en),
        .word(mem_rd_data), .crc(crc)
    );

    ptx_byte_ser #(.WORD_W(32)) ser_i (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .word(ser_word),
        .ready(link_ready), .busy(ser_busy), .byte_o(link_byte)
    );

    assign tag_ready   = !q_full;
    assign chan_req    = (state != ST_IDLE);
    assign mem_rd_addr = cur_addr;
    assign link_valid  = ser_busy;

    // Next-state and per-state strobes.
    always_comb begin
        nxt       = state;
        q_pop     = 1'b0;
        mem_rd_en = 1'b0;
        ser_load  = 1'b0;
        ser_word  = mem_rd_data;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        case (state)
            ST_IDLE:  if (!q_empty) nxt = ST_GRANT;
            ST_GRANT: if (chan_grant) begin
                          q_pop   = 1'b1;
                          crc_clr = 1'b1;
                          nxt     = ST_READ;
                      end
            ST_READ:  begin
                          mem_rd_en = 1'b1;
                          nxt       = ST_DATA;
                      end
            ST_DATA:  begin
                          ser_load = 1'b1;
                          crc_en   = 1'b1;
                          nxt      = ST_WAIT;
                      end
            ST_WAIT:  if (!ser_busy) begin
                          if (rem != '0)    nxt = ST_READ;
                          else if (cur_last) nxt = ST_STAMP;
                          else if (!q_empty) begin
                              q_pop = 1'b1;
                              nxt   = ST_READ;
                          end
                      end
            ST_STAMP: begin
                          ser_load = 1'b1;
                          ser_word = ts_q;
                          nxt      = ST_CRC;
                      end
            ST_CRC:   if (!ser_busy) begin
                          ser_load = 1'b1;
                          ser_word = crc;
                          nxt      = ST_FIN;
                      end
            ST_FIN:   if (!ser_busy) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register and free-running timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ts_cnt <= '0;
        end else begin
            state  <= nxt;
            ts_cnt <= ts_cnt + 1'b1;
        end
    end

    // Page walker: current page pointer, words left, timestamp capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem      <= '0;
            cur_last <= 1'b0;
            ts_q     <= '0;
        end else if (q_pop) begin
            {cur_last, rem, cur_addr} <= head;
        end else if (mem_rd_en) begin
            cur_addr <= cur_addr + 1'b1;
            rem      <= rem - 1'b1;
            if (cur_last && rem == CNT_W'(1)) ts_q <= ts_cnt;
        end
    end

endmodule

// File: rtl/ptx_checker.sv
// Protocol properties for page_tag_tx, bound into every instance.
module ptx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       chan_req,
    input logic       chan_grant,
    input logic       mem_rd_en,
    input logic       link_valid,
    input logic       link_ready,
    input logic [7:0] link_byte
);
    logic granted;

    // Tracks whether the current reservation has been granted.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_req) granted <= 1'b0;
        else if (chan_grant)     granted <= 1'b1;
    end

    // R2
    rd_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> granted);

    // R2
    byte_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> granted);

    // R4
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R5
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !link_ready) |=> (link_valid && $stable(link_byte)));

    // R9
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_req) |-> !link_valid);

endmodule

bind page_tag_tx ptx_checker chk_i (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_grant(chan_grant),
    .mem_rd_en(mem_rd_en), .link_valid(link_valid), .link_ready(link_ready),
    .link_byte(link_byte)
);

// File: tb/page_tag_tx_tb_top.sv
module page_tag_tx_tb_top;
    localparam int AW = 8;
    localparam int CW = 6;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tag_valid = 1'b0;
    logic          tag_ready;
    logic [AW-1:0] tag_addr = '0;
    logic [CW-1:0] tag_count = '0;
    logic          tag_last = 1'b0;
    logic          chan_req;
    logic          chan_grant = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data = '0;
    logic          link_valid;
    logic          link_ready = 1'b0;
    logic [7:0]    link_byte;

    page_tag_tx #(.ADDR_W(AW), .CNT_W(CW), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tag_valid(tag_valid), .tag_ready(tag_ready),
        .tag_addr(tag_addr), .tag_count(tag_count), .tag_last(tag_last),
        .chan_req(chan_req), .chan_grant(chan_grant), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .link_valid(link_valid), .link_ready(link_ready), .link_byte(link_byte)
    );

    always #4 clk = ~clk;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [31:0] mem [256];
    logic [31:0] cyc = '0;
    logic [7:0]  rx_q [$];
    int  ready_mode = 0;      // 0 always ready, 1 random, 2 never
    bit  grant_hold = 0;
    bit  granted = 0;
    int  early = 0, late_bytes = 0;
    int  fetch_cnt = 0, fetch_total = 0;
    logic [31:0] ts_exp = '0;
    int  pa [8];
    int  pc [8];

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 31; i >= 0; i--)
            r = (r[31] ^ d[i]) ? ({r[30:0], 1'b0} ^ 32'h04C11DB7) : {r[30:0], 1'b0};
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model with one cycle of read latency (R4).
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        cyc <= rst_n ? cyc + 1 : 32'd0;
    end

    // Drive link and grant away from the edge, then observe.
    always @(negedge clk) begin
        link_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
        chan_grant = chan_req && !grant_hold && (($urandom % 4) == 0);
        #1;
        if (rst_n) begin
            if ((mem_rd_en || link_valid) && !granted) early++;
            if (!chan_req) granted = 0;
            else if (chan_grant) granted = 1;
            if (link_valid && link_ready) begin
                rx_q.push_back(link_byte);
                if (!chan_req) late_bytes++;
            end
            if (mem_rd_en) begin
                if (fetch_cnt == fetch_total - 1) ts_exp = cyc;
                fetch_cnt++;
            end
        end
    end

    task automatic push_tag(input int a, input int c, input bit last, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        tag_valid = 1'b1; tag_addr = AW'(a); tag_count = CW'(c); tag_last = last;
        while (!tag_ready) @(negedge clk);
        @(negedge clk);
        tag_valid = 1'b0;
    endtask

    // Sends a packet of n tags from pa/pc and checks what the link carried.
    task automatic run_pkt(input int n, input int max_gap, input bit hold_full);
        logic [31:0] exp_w [$];
        logic [31:0] crc, got;
        int nbytes, bad;
        crc = 32'hFFFFFFFF;
        fetch_total = 0;
        for (int t = 0; t < n; t++)
            for (int k = 0; k < pc[t]; k++) begin
                exp_w.push_back(mem[pa[t] + k]);
                crc = crc_ref(crc, mem[pa[t] + k]);
                fetch_total++;
            end
        fetch_cnt = 0; early = 0; late_bytes = 0;
        rx_q.delete();
        if (hold_full) grant_hold = 1;
        fork
            begin
                for (int t = 0; t < n; t++)
                    push_tag(pa[t], pc[t], t == n - 1, max_gap == 0 ? 0 : int'($urandom % max_gap));
                if (hold_full) begin
                    repeat (6) @(negedge clk);
                    chk(tag_ready == 1'b0, "R1", "tag_ready with full queue", tag_ready, 0);
                    chk(rx_q.size() == 0 && fetch_cnt == 0, "R2", "activity before grant",
                        fetch_cnt, 0);
                    grant_hold = 0;
                end
            end
            begin
                wait (chan_req);
                wait (!chan_req);
            end
        join
        repeat (3) @(negedge clk);
        nbytes = 4 * (exp_w.size() + 2);
        chk(rx_q.size() == nbytes, "R6", "byte count", rx_q.size(), nbytes);
        if (rx_q.size() == nbytes) begin
            bad = 0;
            for (int i = 0; i < exp_w.size(); i++) begin
                got = {rx_q[4*i], rx_q[4*i+1], rx_q[4*i+2], rx_q[4*i+3]};
                if (got != exp_w[i] && bad == 0) begin
                    bad = 1;
                    chk(0, "R3/R5", "payload word", got, exp_w[i]);
                end
            end
            if (bad == 0) chk(1, "R3", "payload", 0, 0);
            got = {rx_q[nbytes-8], rx_q[nbytes-7], rx_q[nbytes-6], rx_q[nbytes-5]};
            chk(got == ts_exp, "R7", "timestamp word", got, ts_exp);
            got = {rx_q[nbytes-4], rx_q[nbytes-3], rx_q[nbytes-2], rx_q[nbytes-1]};
            chk(got == crc, "R8", "crc word", got, crc);
        end
        chk(early == 0, "R2", "reads or bytes before grant", early, 0);
        chk(late_bytes == 0, "R9", "bytes after release", late_bytes, 0);
        chk(fetch_cnt == fetch_total, "R10", "fetch count", fetch_cnt, fetch_total);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tag_ready && !chan_req && !mem_rd_en && !link_valid, "R1", "reset state",
            {tag_ready, chan_req, mem_rd_en, link_valid}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Single one-word page (R7 boundary).
        pa[0] = 17; pc[0] = 1;
        run_pkt(1, 0, 0);

        // Non-contiguous pages, random link stalls (R3, R5).
        ready_mode = 1;
        pa[0] = 200; pc[0] = 3; pa[1] = 5; pc[1] = 2; pa[2] = 90; pc[2] = 4;
        run_pkt(3, 0, 0);

        // Slow host between pages (R10).
        pa[0] = 40; pc[0] = 2; pa[1] = 10; pc[1] = 1; pa[2] = 150; pc[2] = 3;
        run_pkt(3, 25, 0);

        // Queue fills while grant is withheld (R1, R2).
        ready_mode = 0;
        pa[0] = 60; pc[0] = 2; pa[1] = 64; pc[1] = 1; pa[2] = 3; pc[2] = 2; pa[3] = 120; pc[3] = 1;
        run_pkt(DEPTH, 0, 1);

        // Random packets back to back; CRC reseeded each time (R8, R9).
        ready_mode = 1;
        for (int p = 0; p < 10; p++) begin
            int n;
            n = 1 + int'($urandom % 6);
            for (int t = 0; t < n; t++) begin
                pc[t] = 1 + int'($urandom % 8);
                pa[t] = int'($urandom % (256 - pc[t]));
            end
            run_pkt(n, (p % 3 == 0) ? 6 : 0, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule